// File: doc/BRIEF.md
# Super-tiled pixel address generator

The block turns a pixel coordinate into the byte address where that pixel is stored, for surfaces kept in memory as 4x4-pixel tiles. Each request carries the coordinate (x, y), two base addresses, a pixel-size code and the surface width counted in 64x64 super-tiles. A two-bit layout code picks one of four arrangements:
- plain tiles in raster order;
- 64x64 super-tiles built from groups of tiles;
- a dual-pipe split variant of each, in which alternate tiles go to a second base address.

Requests enter on a valid/ready handshake. Each address leaves one cycle later from a single registered stage, which is managed by a two-state machine. The stage is either `ST_EMPTY` (no result held) or `ST_FULL` (a result is held on the output):
- From `ST_EMPTY`, an accepted request (`TR_LOAD`) moves it to `ST_FULL`.
- In `ST_FULL`, the stage moves back to `ST_EMPTY` (`TR_DRAIN`) when the output is taken and no new request is presented.
- In `ST_FULL`, the stage stays in `ST_FULL` (`TR_REFILL`) when the output is taken and a new request is accepted in the same cycle.
- In `ST_FULL`, the stage stays in `ST_FULL` (`TR_STALL`) while the output is not taken, and the input is held off.

Top module: `supertile_addr_gen`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted on a clock edge (`in_valid` and `in_ready` high) appears on `out_valid`/`out_addr` right after that edge. `out_valid` is high exactly while an accepted result has not yet been taken. When the stage is empty, `in_ready` is 1.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_addr` holds its value. No accepted request is lost or duplicated.
- R4: Mode 0 (plain tiles) uses tile index ty*(16*W)+tx, where tx=x/4, ty=y/4 and W is `in_width_st`. The pixel offset is tile*16 + (y%4)*4 + x%4, and the base is `in_base0`.
- R5: Mode 1 (super-tiles) uses tile index S*256 + G*8 + T. Here S=(y/64)*W + x/64 is the super-tile, G=((y/16)%4)*8 + (x/8)%8 is the group (8 groups across, 4 down) and T=((y/4)%4)*2 + (x/4)%2 is the tile within the group. The pixel offset is tile*16 + (y%4)*4 + x%4, and the base is `in_base0`.
- R6: Mode 2 (split plain) uses the R4 tile index with its lowest bit removed. The pixel offset is (tile/2)*16 + (y%4)*4 + x%4. The base is `in_base1` when (x/4) is odd and `in_base0` when it is even.
- R7: Mode 3 (split super-tiles) does the same as R6, applied to the R5 tile index.
- R8: `out_addr` = base + (pixel offset << s), modulo 2^ADDR_W. `in_pix_shift` codes 0, 1 and 2 give s = 0, 1 and 2 (1, 2 or 4 bytes per pixel), and code 3 acts as code 2.
- R9: On a 128x128 surface (W=2) with distinct bases, no two pixels map to the same address in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| in_mode | input | 2 | Layout: 0 plain, 1 super, 2 split plain, 3 split super |
| in_pix_shift | input | 2 | log2 of bytes per pixel (3 treated as 2) |
| in_width_st | input | WST_W | Surface width in 64-pixel super-tiles |
| in_base0 | input | ADDR_W | Base address for even tiles and non-split modes |
| in_base1 | input | ADDR_W | Base address for odd tiles in split modes |
| out_valid | output | 1 | Address held on output |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | ADDR_W | Byte address |

## Verification
The bench uses the default widths: 12-bit coordinates, 32-bit addresses and a 6-bit width field. It drives a surface two super-tiles wide, so that every pixel of a 128x128 surface is swept in each mode. At that size, crossings between super-tiles and between groups, the tile-parity base switch and the halving in the split modes all occur many times over, and full uniqueness can be checked. A second phase uses irregular valid and ready patterns to reach every state transition of the stage, including a refill while draining and a long stall. A directed phase exercises each pixel-size code, including code 3.

// File: rtl/supertile_pkg.sv
package supertile_pkg;

    typedef enum logic [1:0] {
        LAYOUT_PLAIN       = 2'd0,
        LAYOUT_SUPER       = 2'd1,
        LAYOUT_SPLIT_PLAIN = 2'd2,
        LAYOUT_SPLIT_SUPER = 2'd3
    } layout_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

    localparam int TILE_LOG2   = 2;   // 4x4 pixel tiles
    localparam int SUPER_LOG2  = 6;   // 64x64 pixel super-tiles
    localparam int INNER_BITS  = 2 * TILE_LOG2;

endpackage

// File: rtl/tile_locator.sv
module tile_locator
    import supertile_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 32,
    parameter int WST_W   = 6
) (
    input  logic [COORD_W-1:0]    x,
    input  logic [COORD_W-1:0]    y,
    input  logic                  super_mode,
    input  logic [WST_W-1:0]      width_st,
    output logic [ADDR_W-1:0]     tile_idx,
    output logic [INNER_BITS-1:0] inner,
    output logic                  odd_tile
);
    localparam int TCOORD_W = COORD_W - TILE_LOG2;
    localparam int SCOORD_W = COORD_W - SUPER_LOG2;

    logic [TCOORD_W-1:0] tx, ty;
    logic [SCOORD_W-1:0] sx, sy;
    logic [ADDR_W-1:0]   tiles_per_row;
    logic [ADDR_W-1:0]   plain_idx;
    logic [ADDR_W-1:0]   super_num;
    logic [ADDR_W-1:0]   super_idx;

    always_comb begin
        tx = x[COORD_W-1:TILE_LOG2];
        ty = y[COORD_W-1:TILE_LOG2];
        sx = x[COORD_W-1:SUPER_LOG2];
        sy = y[COORD_W-1:SUPER_LOG2];
        inner = {y[TILE_LOG2-1:0], x[TILE_LOG2-1:0]};
        odd_tile = x[TILE_LOG2];

        // Raster order of 4x4 tiles; one super-tile spans 16 tiles across.
        tiles_per_row = ADDR_W'(width_st) << (SUPER_LOG2 - TILE_LOG2);
        plain_idx = ADDR_W'(ty) * tiles_per_row + ADDR_W'(tx);

        // Super-tile number, then group (3 bits across, 2 down), then tile (1 across, 2 down).
        super_num = ADDR_W'(sy) * ADDR_W'(width_st) + ADDR_W'(sx);
        super_idx = (super_num << 8)
                  | ADDR_W'({y[5:4], x[5:3], y[3:2], x[2]});

        tile_idx = super_mode ? super_idx : plain_idx;
    end
endmodule

// File: rtl/addr_composer.sv
module addr_composer
    import supertile_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]     tile_idx,
    input  logic [INNER_BITS-1:0] inner,
    input  logic                  split,
    input  logic                  odd_tile,
    input  logic [1:0]            pix_shift,
    input  logic [ADDR_W-1:0]     base0,
    input  logic [ADDR_W-1:0]     base1,
    output logic [ADDR_W-1:0]     addr
);
    logic [ADDR_W-1:0] tile_sel;
    logic [ADDR_W-1:0] pix_off;
    logic [1:0]        shamt;
    logic [ADDR_W-1:0] base_sel;

    always_comb begin
        tile_sel = split ? (tile_idx >> 1) : tile_idx;
        pix_off  = (tile_sel << INNER_BITS) | ADDR_W'(inner);
        shamt    = (pix_shift == 2'd3) ? 2'd2 : pix_shift;
        base_sel = (split && odd_tile) ? base1 : base0;
        addr     = base_sel + (pix_off << shamt);
    end
endmodule

// File: rtl/supertile_addr_gen.sv
module supertile_addr_gen
    import supertile_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 32,
    parameter int WST_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [1:0]         in_mode,
    input  logic [1:0]         in_pix_shift,
    input  logic [WST_W-1:0]   in_width_st,
    input  logic [ADDR_W-1:0]  in_base0,
    input  logic [ADDR_W-1:0]  in_base1,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr
);
    stage_state_e state_q, state_d;

    logic [ADDR_W-1:0]     tile_idx;
    logic [INNER_BITS-1:0] inner;
    logic                  odd_tile;
    logic [ADDR_W-1:0]     addr_d;
    logic [ADDR_W-1:0]     addr_q;
    logic                  load;
    layout_e               layout;

    assign layout = layout_e'(in_mode);

    tile_locator #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .WST_W(WST_W)) u_loc (
        .x          (in_x),
        .y          (in_y),
        .super_mode (layout == LAYOUT_SUPER || layout == LAYOUT_SPLIT_SUPER),
        .width_st   (in_width_st),
        .tile_idx   (tile_idx),
        .inner      (inner),
        .odd_tile   (odd_tile)
    );

    addr_composer #(.ADDR_W(ADDR_W)) u_comp (
        .tile_idx  (tile_idx),
        .inner     (inner),
        .split     (layout == LAYOUT_SPLIT_PLAIN || layout == LAYOUT_SPLIT_SUPER),
        .odd_tile  (odd_tile),
        .pix_shift (in_pix_shift),
        .base0     (in_base0),
        .base1     (in_base1),
        .addr      (addr_d)
    );

    // Next-state logic: TR_LOAD, TR_DRAIN, TR_REFILL, TR_STALL.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
        endcase
    end

    assign load = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= addr_d;
    end

    assign out_addr = addr_q;
endmodule

// File: rtl/supertile_addr_gen_chk.sv
module supertile_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr
);
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_empty_ready_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_stall_block_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
endmodule

bind supertile_addr_gen supertile_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr)
);

// File: tb/supertile_addr_gen_bench.sv
module supertile_addr_gen_bench;
    localparam int COORD_W = 12;
    localparam int ADDR_W  = 32;
    localparam int WST_W   = 6;
    localparam int SURF    = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [COORD_W-1:0] in_x = '0, in_y = '0;
    logic [1:0] in_mode = '0, in_pix_shift = 2'd2;
    logic [WST_W-1:0] in_width_st = WST_W'(2);
    logic [ADDR_W-1:0] in_base0 = 32'h0010_0000, in_base1 = 32'h0080_0000;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [ADDR_W-1:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint unsigned exp_q[$];
    string           tag_q[$];
    bit              seen[longint unsigned];
    bit              track_unique = 0;

    always #5 clk = ~clk;

    supertile_addr_gen #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .WST_W(WST_W)) u_supertile_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_mode(in_mode), .in_pix_shift(in_pix_shift),
        .in_width_st(in_width_st), .in_base0(in_base0), .in_base1(in_base1),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
    );

    function automatic longint unsigned ref_addr(int x, int y, int mode, int sh, int w,
                                                 longint unsigned b0, longint unsigned b1);
        longint unsigned tile, off, base;
        int tx = x / 4, ty = y / 4;
        int inner = (y % 4) * 4 + (x % 4);
        int s = (sh == 3) ? 2 : sh;
        if (mode % 2 == 0)
            tile = longint'(ty) * (w * 16) + tx;
        else
            tile = (longint'(y / 64) * w + x / 64) * 256 + ((y / 16) % 4) * 64
                 + ((x / 8) % 8) * 8 + (ty % 4) * 2 + (tx % 2);
        if (mode >= 2) begin
            off  = (tile / 2) * 16 + inner;
            base = (tx % 2 == 1) ? b1 : b0;
        end else begin
            off  = tile * 16 + inner;
            base = b0;
        end
        return (base + (off << s)) & 64'hFFFF_FFFF;
    endfunction

    function automatic string mode_tag(int mode, int sh);
        if (sh != 2) return "R8";
        case (mode)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: apply inputs at the falling edge, then evaluate what the next rising edge will do.
    task automatic cycle(bit v, int x, int y, int mode, int sh, bit ordy, output bit accepted);
        @(negedge clk);
        in_valid = v; in_x = COORD_W'(x); in_y = COORD_W'(y);
        in_mode = 2'(mode); in_pix_shift = 2'(sh); out_ready = ordy;
        #1;
        check(out_valid == (exp_q.size() != 0), "R2", "out_valid vs pending", out_valid, exp_q.size() != 0);
        if (out_valid && !out_ready)
            check(in_ready == 1'b0, "R3", "in_ready during stall", in_ready, 0);
        if (!out_valid)
            check(in_ready == 1'b1, "R2", "in_ready when empty", in_ready, 1);
        if (out_valid && out_ready && exp_q.size() != 0) begin
            longint unsigned e = exp_q.pop_front();
            string t = tag_q.pop_front();
            check(out_addr == e[31:0], t, "address", out_addr, e);
            if (track_unique) begin
                check(!seen.exists(out_addr), "R9", "address reused", out_addr, 0);
                seen[out_addr] = 1;
            end
        end
        accepted = v && in_ready;
        if (accepted) begin
            exp_q.push_back(ref_addr(x, y, mode, sh, 2, in_base0, in_base1));
            tag_q.push_back(mode_tag(mode, sh));
        end
    endtask

    task automatic drain();
        bit a;
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 2, 1, a);
    endtask

    initial begin
        bit acc;
        int lfsr = 32'h1ACE5;
        // Reset state
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        @(negedge clk); rst = 1'b0; #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // Full sweep per mode with uniqueness tracking
        for (int m = 0; m < 4; m++) begin
            seen.delete();
            track_unique = 1;
            for (int y = 0; y < SURF; y++)
                for (int x = 0; x < SURF; x++)
                    cycle(1, x, y, m, 2, 1, acc);
            drain();
            check(seen.num() == SURF * SURF, "R9", "distinct addresses", seen.num(), SURF * SURF);
            track_unique = 0;
        end

        // Pixel size codes
        for (int sh = 0; sh < 4; sh++)
            for (int k = 0; k < 8; k++)
                cycle(1, 13 + k * 9, 70 + k * 5, k % 4, sh, 1, acc);
        drain();

        // Irregular handshake traffic, including stalls and refills
        begin
            int px = 0, py = 0, pm = 0;
            bit pend = 0;
            for (int i = 0; i < 3000; i++) begin
                bit v, r;
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                if (!pend) begin
                    v = lfsr[0] | lfsr[3];
                    if (v) begin
                        px = (lfsr >> 4) % SURF; py = (lfsr >> 11) % SURF; pm = (lfsr >> 2) % 4;
                        pend = 1;
                    end
                end
                v = pend;
                r = (i > 2000 && i < 2040) ? 1'b0 : (lfsr[5] | lfsr[7]);
                cycle(v, px, py, pm, 2, r, acc);
                if (acc) pend = 0;
            end
            drain();
        end
        check(exp_q.size() == 0, "R3", "results left undelivered", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule